// File: doc/BRIEF.md
# Drum Sector Transfer Engine

This block copies one sector of a word-addressed drum store to or from main memory. A start strobe latches the direction, the sector number and the first memory address. From then on, every word-time tick moves one word. The word's drum location is the sector number placed above the word offset. The memory location comes from a running address that steps once per word and wraps at its width.

Reads place drum words into memory, but only where the memory address falls inside the installed memory. Words aimed beyond that limit are discarded. Writes place memory words onto the drum unless the sector belongs to a locked group: each bit of a lock mask covers a run of consecutive sectors. A locked word leaves the drum untouched and raises the error flag. The pass still continues to the end of the sector, and the addresses keep stepping. When the last word is done, the sector number advances with wrap-around and `done` rises. If the drum is reported absent at start, error and done are raised at once and nothing moves.

Top module: `sector_xfer_engine`

## Requirements
- R1: A start seen while `busy` is low loads `start_sector`, `start_maddr` and `xfer_write`, and resets the word offset to 0. With `drum_present` high it also raises `busy` and clears `done` and `err` at the same edge. A start seen while `busy` is high is ignored.
- R2: `drum_addr` equals `sector_addr`×256 plus the word offset. The offset advances only on an edge where `word_tick` and `busy` are both high. One operation spans exactly 256 such ticks.
- R3: On a read (`xfer_write`=0), each tick cycle drives `mem_we` high with `mem_wdata` equal to `drum_rdata`, but only if `mem_addr` is below INSTALLED_WORDS (default 32768). Otherwise `mem_we` stays low.
- R4: `mem_addr` increases by one modulo 65536 on every tick edge while busy, whether or not the word was stored.
- R5: On a write (`xfer_write`=1), each tick cycle drives `drum_we` high with `drum_wdata` equal to `mem_rdata`, unless bit `sector_addr[8:4]` of `lock_mask` is set. In that case `drum_we` stays low and `err` is set at that edge.
- R6: A lock error does not end the operation. The remaining ticks are still consumed, and `err` stays high until the next accepted start.
- R7: At the edge of the 256th tick, `busy` falls, `done` rises, and `sector_addr` increases by one modulo 512.
- R8: A start accepted with `drum_present` low sets `done` and `err` at the next edge. `busy` stays low and no write strobe follows.
- R9: After reset, `busy`, `done`, `err`, `sector_addr`, `mem_addr` and `drum_addr` are all 0.
- R10: `mem_we` and `drum_we` are low in every cycle where `busy` or `word_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (ignored while busy) |
| xfer_write | input | 1 | 1 = memory to drum, 0 = drum to memory |
| start_sector | input | 9 | Sector number to transfer |
| start_maddr | input | 16 | First memory address |
| lock_mask | input | 32 | One lock bit per group of 16 sectors |
| drum_present | input | 1 | Drum storage is available |
| word_tick | input | 1 | Word-time strobe; one word per tick |
| mem_addr | output | 16 | Current memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 18 | Word to memory |
| mem_rdata | input | 18 | Word from memory at `mem_addr` (combinational) |
| drum_addr | output | 17 | Current drum word address |
| drum_we | output | 1 | Drum write strobe |
| drum_wdata | output | 18 | Word to drum |
| drum_rdata | input | 18 | Word from drum at `drum_addr` (combinational) |
| sector_addr | output | 9 | Current sector number |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last operation finished |
| err | output | 1 | Lock violation or absent drum |

## Verification
The write strobes and write data are combinational, so they are due in the same cycle as the tick that causes them. Addresses, `busy`, `done` and `err` change at the first clock edge after a tick or an accepted start. That holds for the completion step on the 256th tick as well. The bench drives inputs and compares everything at the falling edge. It first compares the strobes against its model's state as it stands before the coming edge. It then advances the model on the rising edge, so the register outputs are checked one edge after their cause and never earlier.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic {
      XFER_RD = 1'b0,
      XFER_WR = 1'b1
   } xfer_op_t;

endpackage

// File: rtl/xfer_wrap_counter.sv
module xfer_wrap_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         last
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_r <= '0;
      else if (load)
         q_r <= load_val;
      else if (inc)
         q_r <= q_r + W'(1);
   end

   assign q    = q_r;
   assign last = &q_r;

endmodule

// File: rtl/xfer_lock_gate.sv
module xfer_lock_gate #(
   parameter int SECTOR_W        = 9,
   parameter int MEM_AW          = 16,
   parameter int LOCK_W          = 32,
   parameter int LOCK_SHIFT      = 4,
   parameter int INSTALLED_WORDS = 32768,
   parameter bit MEM_CHECK_EN    = 1'b1
) (
   input  logic [SECTOR_W-1:0] sector_i,
   input  logic [MEM_AW-1:0]   maddr_i,
   input  logic [LOCK_W-1:0]   lock_mask_i,
   output logic                locked_o,
   output logic                mem_ok_o
);

   localparam int LIDX_W = SECTOR_W - LOCK_SHIFT;
   localparam logic [MEM_AW:0] MEM_LIMIT = (MEM_AW + 1)'(INSTALLED_WORDS);

   logic [LIDX_W-1:0] lidx;
   assign lidx     = sector_i[SECTOR_W-1:LOCK_SHIFT];
   assign locked_o = lock_mask_i[lidx];

   generate
      if (MEM_CHECK_EN) begin : g_mem_limit
         assign mem_ok_o = ({1'b0, maddr_i} < MEM_LIMIT);
      end else begin : g_mem_full
         assign mem_ok_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sector_xfer_engine.sv
module sector_xfer_engine
   import xfer_pkg::*;
#(
   parameter int SECTOR_W        = 9,
   parameter int WORD_W          = 8,
   parameter int MEM_AW          = 16,
   parameter int DATA_W          = 18,
   parameter int LOCK_W          = 32,
   parameter int LOCK_SHIFT      = 4,
   parameter int INSTALLED_WORDS = 32768,
   parameter bit MEM_CHECK_EN    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         xfer_write,
   input  logic [SECTOR_W-1:0]          start_sector,
   input  logic [MEM_AW-1:0]            start_maddr,
   input  logic [LOCK_W-1:0]            lock_mask,
   input  logic                         drum_present,
   input  logic                         word_tick,
   output logic [MEM_AW-1:0]            mem_addr,
   output logic                         mem_we,
   output logic [DATA_W-1:0]            mem_wdata,
   input  logic [DATA_W-1:0]            mem_rdata,
   output logic [SECTOR_W+WORD_W-1:0]   drum_addr,
   output logic                         drum_we,
   output logic [DATA_W-1:0]            drum_wdata,
   input  logic [DATA_W-1:0]            drum_rdata,
   output logic [SECTOR_W-1:0]          sector_addr,
   output logic                         busy,
   output logic                         done,
   output logic                         err
);

   localparam int DRUM_AW = SECTOR_W + WORD_W;

   // elaboration-time parameter checks
   generate
      if ((LOCK_W << LOCK_SHIFT) != (1 << SECTOR_W)) begin : g_bad_lock_geom
         $error("lock mask must cover every sector exactly once");
      end
      if (INSTALLED_WORDS > (1 << MEM_AW) || INSTALLED_WORDS < 1) begin : g_bad_mem_size
         $error("INSTALLED_WORDS out of range for MEM_AW");
      end
      if (DRUM_AW > 30) begin : g_bad_drum_width
         $error("drum address too wide");
      end
   endgenerate

   xfer_op_t op_q;
   logic busy_q, done_q, err_q;
   logic accept, step, last_word, fin;
   logic locked, mem_ok;
   logic [WORD_W-1:0] word_off;

   assign accept = start & ~busy_q;
   assign step   = busy_q & word_tick;
   assign fin    = step & last_word;

   xfer_wrap_counter #(.W(WORD_W)) u_word_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val ('0),
      .inc      (step),
      .q        (word_off),
      .last     (last_word)
   );

   logic sec_last_unused, ma_last_unused;

   xfer_wrap_counter #(.W(SECTOR_W)) u_sector_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (start_sector),
      .inc      (fin),
      .q        (sector_addr),
      .last     (sec_last_unused)
   );

   xfer_wrap_counter #(.W(MEM_AW)) u_maddr_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (start_maddr),
      .inc      (step),
      .q        (mem_addr),
      .last     (ma_last_unused)
   );

   xfer_lock_gate #(
      .SECTOR_W        (SECTOR_W),
      .MEM_AW          (MEM_AW),
      .LOCK_W          (LOCK_W),
      .LOCK_SHIFT      (LOCK_SHIFT),
      .INSTALLED_WORDS (INSTALLED_WORDS),
      .MEM_CHECK_EN    (MEM_CHECK_EN)
   ) u_gate (
      .sector_i    (sector_addr),
      .maddr_i     (mem_addr),
      .lock_mask_i (lock_mask),
      .locked_o    (locked),
      .mem_ok_o    (mem_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= XFER_RD;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (accept) begin
         op_q   <= xfer_op_t'(xfer_write);
         busy_q <= drum_present;
         done_q <= ~drum_present;
         err_q  <= ~drum_present;
      end else if (step) begin
         if (op_q == XFER_WR && locked)
            err_q <= 1'b1;
         if (fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign drum_addr  = {sector_addr, word_off};
   assign mem_we     = step & (op_q == XFER_RD) & mem_ok;
   assign mem_wdata  = drum_rdata;
   assign drum_we    = step & (op_q == XFER_WR) & ~locked;
   assign drum_wdata = mem_rdata;
   assign busy       = busy_q;
   assign done       = done_q;
   assign err        = err_q;

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
   parameter int SECTOR_W        = 9,
   parameter int MEM_AW          = 16,
   parameter int LOCK_W          = 32,
   parameter int LOCK_SHIFT      = 4,
   parameter int INSTALLED_WORDS = 32768
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                drum_present,
   input logic                word_tick,
   input logic [LOCK_W-1:0]   lock_mask,
   input logic [MEM_AW-1:0]   mem_addr,
   input logic                mem_we,
   input logic                drum_we,
   input logic [SECTOR_W-1:0] sector_addr,
   input logic                busy,
   input logic                done
);

   // R7
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R10
   strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || drum_we) |-> (busy && word_tick && !(mem_we && drum_we)));

   // R5
   lock_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drum_we |-> !lock_mask[sector_addr[SECTOR_W-1:LOCK_SHIFT]]);

   // R3
   mem_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (32'(mem_addr) < INSTALLED_WORDS));

   // R4
   maddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && word_tick) |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

   // R7
   sector_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && sector_addr == SECTOR_W'($past(sector_addr) + 1'b1)));

   // R8
   absent_drum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !drum_present) |=> (done && !busy));

endmodule

bind sector_xfer_engine xfer_engine_chk #(
   .SECTOR_W        (SECTOR_W),
   .MEM_AW          (MEM_AW),
   .LOCK_W          (LOCK_W),
   .LOCK_SHIFT      (LOCK_SHIFT),
   .INSTALLED_WORDS (INSTALLED_WORDS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .drum_present (drum_present),
   .word_tick    (word_tick),
   .lock_mask    (lock_mask),
   .mem_addr     (mem_addr),
   .mem_we       (mem_we),
   .drum_we      (drum_we),
   .sector_addr  (sector_addr),
   .busy         (busy),
   .done         (done)
);

// File: tb/tb_sector_xfer_engine.sv
module tb_sector_xfer_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        xfer_write = 1'b0;
   logic [8:0]  start_sector = '0;
   logic [15:0] start_maddr = '0;
   logic [31:0] lock_mask = '0;
   logic        drum_present = 1'b1;
   logic        word_tick = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [17:0] mem_wdata;
   logic [17:0] mem_rdata = '0;
   logic [16:0] drum_addr;
   logic        drum_we;
   logic [17:0] drum_wdata;
   logic [17:0] drum_rdata = '0;
   logic [8:0]  sector_addr;
   logic        busy, done, err;

   always #5 clk = ~clk;

   sector_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_write(xfer_write),
      .start_sector(start_sector), .start_maddr(start_maddr),
      .lock_mask(lock_mask), .drum_present(drum_present), .word_tick(word_tick),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .drum_addr(drum_addr), .drum_we(drum_we),
      .drum_wdata(drum_wdata), .drum_rdata(drum_rdata),
      .sector_addr(sector_addr), .busy(busy), .done(done), .err(err)
   );

   // behavioural storage: untouched words follow a formula, written ones are recorded
   logic [17:0] mem_st  [int];
   logic [17:0] drum_st [int];

   function automatic logic [17:0] mem_rd(int a);
      if (mem_st.exists(a)) return mem_st[a];
      return 18'((a * 53 + 7) & 32'h3FFFF);
   endfunction

   function automatic logic [17:0] drum_rd(int a);
      if (drum_st.exists(a)) return drum_st[a];
      return 18'((a * 37 + 11) & 32'h3FFFF);
   endfunction

   // reference model state
   int m_busy = 0, m_done = 0, m_err = 0, m_sec = 0, m_ma = 0, m_cnt = 0, m_wr = 0;

   int vectors = 0, miscompares = 0;
   bit finished = 1'b0;

   task automatic chk(string req, string nm, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
      end
   endtask

   // one clock: drive at falling edge, compare, advance model on rising edge
   task automatic cyc(input logic st, input logic tk);
      int e_mwe, e_dwe, e_mwd, e_dwd, e_daddr;
      start     = st;
      word_tick = tk;
      e_daddr    = m_sec * 256 + m_cnt;
      drum_rdata = drum_rd(e_daddr);
      mem_rdata  = mem_rd(m_ma);
      e_mwe = (m_busy && tk && !m_wr && m_ma < 32768) ? 1 : 0;
      e_dwe = (m_busy && tk && m_wr && !lock_mask[m_sec >> 4]) ? 1 : 0;
      e_mwd = drum_rdata;
      e_dwd = mem_rdata;
      #1;
      chk("R1", "busy", busy, m_busy);
      chk("R7", "done", done, m_done);
      chk("R6", "err", err, m_err);
      chk("R7", "sector_addr", sector_addr, m_sec);
      chk("R4", "mem_addr", mem_addr, m_ma);
      chk("R2", "drum_addr", drum_addr, e_daddr);
      chk("R3", "mem_we", mem_we, e_mwe);
      chk("R5", "drum_we", drum_we, e_dwe);
      if (e_mwe != 0) chk("R3", "mem_wdata", mem_wdata, e_mwd);
      if (e_dwe != 0) chk("R5", "drum_wdata", drum_wdata, e_dwd);
      @(posedge clk);
      if (e_mwe != 0) mem_st[m_ma] = 18'(e_mwd);
      if (e_dwe != 0) drum_st[e_daddr] = 18'(e_dwd);
      if (st && !m_busy) begin
         m_sec = start_sector; m_ma = start_maddr; m_cnt = 0; m_wr = xfer_write;
         if (drum_present) begin m_busy = 1; m_done = 0; m_err = 0; end
         else begin m_done = 1; m_err = 1; end
      end else if (m_busy && tk) begin
         if (m_wr && lock_mask[m_sec >> 4]) m_err = 1;
         m_ma = (m_ma + 1) % 65536;
         m_cnt++;
         if (m_cnt == 256) begin
            m_cnt = 0; m_busy = 0; m_done = 1; m_sec = (m_sec + 1) % 512;
         end
      end
      @(negedge clk);
   endtask

   // full operation; ticks every 'gap' cycles, optional stray start mid-way
   task automatic run_op(input logic wr, input int sec, input int ma, input int gap,
                         input bit stray_start);
      int i;
      xfer_write   = wr;
      start_sector = 9'(sec);
      start_maddr  = 16'(ma);
      cyc(1'b1, 1'b0);
      i = 0;
      while (m_busy != 0) begin
         if (stray_start && i == 40) begin
            // R1: start while busy must be ignored
            start_sector = 9'(sec + 7);
            start_maddr  = 16'(ma + 99);
            xfer_write   = ~wr;
            cyc(1'b1, (i % gap) == 0);
         end else begin
            cyc(1'b0, (i % gap) == 0);
         end
         i++;
      end
      cyc(1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R9: reset state checked while still in reset
      cyc(1'b0, 1'b1);
      rst_n = 1'b1;
      cyc(1'b0, 1'b1);                       // R10: idle ticks cause no strobes
      run_op(1'b0, 5,   16'h0100, 1, 1'b0);  // R2 R3 plain read
      run_op(1'b0, 6,   16'h7F80, 3, 1'b0);  // R3 crosses installed-memory limit
      run_op(1'b1, 3,   16'hFFC0, 2, 1'b0);  // R4 R5 write, memory address wraps
      run_op(1'b0, 3,   16'h0400, 1, 1'b0);  // R5 read back written sector
      lock_mask = 32'h0000_0004;             // sectors 32..47 locked
      run_op(1'b1, 35,  16'h1000, 1, 1'b1);  // R5 R6 locked write, R1 stray start
      run_op(1'b0, 35,  16'h2000, 2, 1'b0);  // R5 locked sector unchanged
      run_op(1'b1, 511, 16'h3000, 1, 1'b0);  // R7 sector wraps to 0
      drum_present = 1'b0;
      xfer_write   = 1'b1;
      start_sector = 9'd20;
      start_maddr  = 16'h0042;
      cyc(1'b1, 1'b1);                       // R8 absent drum
      repeat (4) cyc(1'b0, 1'b1);            // R8 R10 no strobes afterwards
      drum_present = 1'b1;
      run_op(1'b0, 0,   16'h5000, 1, 1'b0);  // R1 start clears err/done
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule